// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns an addressing-mode code and its operands into the effective address of a data access. It takes a base register value, an index register value, a two-bit scale code and a 16-bit signed displacement. Every mode is computed as a special case of one general form: base plus scaled index plus displacement, with some terms forced to zero. For the two operand modes (register and immediate), the same output carries the operand value and no address.

A request is accepted on a clock edge with `start` high. Single-step modes present their result one cycle later with a one-cycle `ea_valid` pulse. The auto-increment and auto-decrement modes also return a new base-register value on `wb_data` with `wb_valid`. Memory-indirect mode issues a read on a simple request/acknowledge port at the base address. The word that comes back becomes the effective address. While that read is pending the unit reports `busy` and ignores new requests.

Top module: `eag_top`

## Requirements
- R1: After a synchronous reset, `ea_valid`, `wb_valid`, `mem_req` and `busy` are low and `ea` is zero.
- R2: Mode codes are: 0 register, 1 immediate, 2 register indirect, 3 displacement, 4 indexed, 5 direct, 6 memory indirect, 7 auto-increment, 8 auto-decrement, 9 scaled. For every accepted mode other than 6, `ea_valid` is high in the cycle right after the accepting edge.
- R3: Register mode returns `base_val` on `ea`. Immediate mode returns the displacement sign-extended to 32 bits.
- R4: Register-indirect mode returns `base_val` unchanged. Direct mode returns the sign-extended displacement as the address.
- R5: Displacement mode returns `base_val` plus the sign-extended displacement. Indexed mode returns `base_val` plus `index_val`. Both wrap modulo 2^32.
- R6: Scaled mode returns `base_val + index_val*S + sext(disp)` modulo 2^32, where scale code 0,1,2,3 gives S = 1,2,4,8.
- R7: Auto-increment returns `ea = base_val` and, in the same cycle, `wb_valid` high with `wb_data = base_val + S`. The sum wraps modulo 2^32.
- R8: Auto-decrement decrements before use: `ea` and `wb_data` both equal `base_val - S` modulo 2^32, with `wb_valid` high.
- R9: Memory indirect raises `mem_req` in the cycle after the accepting edge, with `mem_addr = base_val`. Both are held until an edge with `mem_ack` high. In the cycle after that edge, `mem_req` is low, `ea_valid` is high and `ea` equals the `mem_rdata` sampled at that edge. `ea_valid` stays low while the read is pending.
- R10: `busy` is high while the memory read is pending. A `start` seen while `busy` is high produces no `ea_valid`, no `wb_valid` and no new read.
- R11: Mode codes 10 to 15 produce no `ea_valid`, no `wb_valid` and no `mem_req`.
- R12: `wb_valid` is high only in the result cycle of modes 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled on the rising edge |
| mode | input | 4 | Addressing-mode code |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Element size code (1,2,4,8 bytes) |
| disp | input | 16 | Signed displacement / immediate |
| busy | output | 1 | Memory-indirect read pending |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 32 | Memory read data |
| ea_valid | output | 1 | Result strobe |
| ea | output | 32 | Effective address or operand value |
| wb_valid | output | 1 | Base writeback strobe |
| wb_data | output | 32 | New base register value |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, a 16-bit displacement and a 2-bit scale code. These widths reach every scale factor from 1 to 8, negative displacements and wraparound at both ends of the address space. Memory-indirect reads are acknowledged after zero to three extra cycles, so the bench sees both an immediate acknowledge and long waits. Blocked requests arrive during those waits, and undefined mode codes are mixed into the random traffic.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    AM_REG    = 4'd0,
    AM_IMM    = 4'd1,
    AM_RIND   = 4'd2,
    AM_DISP   = 4'd3,
    AM_IDX    = 4'd4,
    AM_DIR    = 4'd5,
    AM_MIND   = 4'd6,
    AM_AINC   = 4'd7,
    AM_ADEC   = 4'd8,
    AM_SCALED = 4'd9
  } am_e;

  localparam logic [3:0] AM_LAST = 4'd9;
endpackage

// File: rtl/eag_scaler.sv
module eag_scaler #(
  parameter int AW  = 32,
  parameter int SCW = 2
) (
  input  logic [AW-1:0]  val,
  input  logic [SCW-1:0] code,
  output logic [AW-1:0]  shifted
);
  localparam int NS = 1 << SCW;

  logic [AW-1:0] cand [NS];

  // one pre-shifted copy per scale code, then a plain mux
  for (genvar g = 0; g < NS; g++) begin : g_shift
    assign cand[g] = val << g;
  end

  assign shifted = cand[code];
endmodule

// File: rtl/eag_addcalc.sv
module eag_addcalc
  import eag_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int SCW = 2
) (
  input  logic [3:0]     mode,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  index,
  input  logic [SCW-1:0] scale,
  input  logic [DW-1:0]  disp,
  output logic [AW-1:0]  addr,
  output logic [AW-1:0]  wb_val,
  output logic           wb_en,
  output logic           known,
  output logic           is_mind
);
  localparam int XW = AW - DW;

  logic [AW-1:0] disp_x;
  logic [AW-1:0] idx_sh;
  logic [AW-1:0] step;
  logic [AW-1:0] t_base, t_idx, t_disp;

  assign disp_x = {{XW{disp[DW-1]}}, disp};

  eag_scaler #(.AW(AW), .SCW(SCW)) u_idx_scale (
    .val(index), .code(scale), .shifted(idx_sh)
  );

  eag_scaler #(.AW(AW), .SCW(SCW)) u_step (
    .val(AW'(1)), .code(scale), .shifted(step)
  );

  // every mode picks its three terms of base + index*S + disp
  always_comb begin
    t_base  = '0;
    t_idx   = '0;
    t_disp  = '0;
    wb_en   = 1'b0;
    wb_val  = base;
    known   = (mode <= AM_LAST);
    is_mind = 1'b0;
    case (mode)
      AM_REG:    t_base = base;
      AM_IMM:    t_disp = disp_x;
      AM_RIND:   t_base = base;
      AM_DISP:   begin t_base = base; t_disp = disp_x; end
      AM_IDX:    begin t_base = base; t_idx = index; end
      AM_DIR:    t_disp = disp_x;
      AM_MIND:   begin t_base = base; is_mind = 1'b1; end
      AM_AINC:   begin t_base = base; wb_en = 1'b1; wb_val = base + step; end
      AM_ADEC:   begin t_base = base - step; wb_en = 1'b1; wb_val = base - step; end
      AM_SCALED: begin t_base = base; t_idx = idx_sh; t_disp = disp_x; end
      default:   ;
    endcase
  end

  assign addr = t_base + t_idx + t_disp;
endmodule

// File: rtl/eag_indir.sv
module eag_indir #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [AW-1:0] ptr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          got,
  output logic [AW-1:0] got_data
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_addr <= '0;
    end else begin
      case (st)
        ST_IDLE: if (launch) begin
          st       <= ST_WAIT;
          mem_addr <= ptr;
        end
        ST_WAIT: if (mem_ack) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (st == ST_WAIT);
  assign got      = mem_req && mem_ack;
  assign got_data = mem_rdata;

  // R9: request held until acknowledged
  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req);
  // R9: address stable while waiting
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> $stable(mem_addr));
  // R10: no new launch while a read is pending
  a_r10_no_relaunch: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !launch);
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int SCW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [3:0]     mode,
  input  logic [AW-1:0]  base_val,
  input  logic [AW-1:0]  index_val,
  input  logic [SCW-1:0] scale_code,
  input  logic [DW-1:0]  disp,
  output logic           busy,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ack,
  input  logic [AW-1:0]  mem_rdata,
  output logic           ea_valid,
  output logic [AW-1:0]  ea,
  output logic           wb_valid,
  output logic [AW-1:0]  wb_data
);
  logic [AW-1:0] c_addr, c_wb;
  logic          c_wb_en, c_known, c_mind;
  logic          accept, launch, got;
  logic [AW-1:0] got_data;

  eag_addcalc #(.AW(AW), .DW(DW), .SCW(SCW)) u_calc (
    .mode(mode), .base(base_val), .index(index_val), .scale(scale_code),
    .disp(disp), .addr(c_addr), .wb_val(c_wb), .wb_en(c_wb_en),
    .known(c_known), .is_mind(c_mind)
  );

  assign accept = start && !busy && c_known;
  assign launch = accept && c_mind;

  eag_indir #(.AW(AW)) u_indir (
    .clk(clk), .rst(rst), .launch(launch), .ptr(base_val),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .got(got), .got_data(got_data)
  );

  assign busy = mem_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid <= 1'b0;
      wb_valid <= 1'b0;
      ea       <= '0;
      wb_data  <= '0;
    end else begin
      ea_valid <= 1'b0;
      wb_valid <= 1'b0;
      if (got) begin
        ea       <= got_data;
        ea_valid <= 1'b1;
      end else if (accept && !c_mind) begin
        ea       <= c_addr;
        ea_valid <= 1'b1;
        wb_valid <= c_wb_en;
        if (c_wb_en) wb_data <= c_wb;
      end
    end
  end

  // R12: writeback only alongside a result
  a_r12_wb_with_ea: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> ea_valid);
  // R9: no result while the indirect read is outstanding
  a_r9_quiet_wait: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !ea_valid);
  // R9: acknowledged read yields a result next cycle
  a_r9_ack_result: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> ea_valid && !mem_req);
  // R11: undefined code never starts anything
  a_r11_undef_quiet: assert property (@(posedge clk) disable iff (rst)
    start && !busy && (mode > AM_LAST) |=> !ea_valid && !mem_req);
endmodule

// File: tb/sim_eag_top.sv
module sim_eag_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [3:0]  mode;
  logic [31:0] base_val, index_val;
  logic [1:0]  scale_code;
  logic [15:0] disp;
  logic        busy, mem_req, mem_ack, ea_valid, wb_valid;
  logic [31:0] mem_addr, mem_rdata, ea, wb_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  eag_top u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base_val(base_val),
    .index_val(index_val), .scale_code(scale_code), .disp(disp), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ea_valid(ea_valid), .ea(ea),
    .wb_valid(wb_valid), .wb_data(wb_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<=100000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] d);
    return {{16{d[15]}}, d};
  endfunction

  function automatic logic [31:0] esz(input logic [1:0] s);
    case (s)
      2'd0: return 32'd1;
      2'd1: return 32'd2;
      2'd2: return 32'd4;
      default: return 32'd8;
    endcase
  endfunction

  function automatic logic [31:0] exp_ea(input logic [3:0] m, input logic [31:0] b,
      input logic [31:0] i, input logic [1:0] s, input logic [15:0] d);
    case (m)
      4'd0, 4'd2, 4'd7: return b;
      4'd1, 4'd5:       return sx(d);
      4'd3:             return b + sx(d);
      4'd4:             return b + i;
      4'd8:             return b - esz(s);
      4'd9:             return b + i * esz(s) + sx(d);
      default:          return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_0F0F;
  endfunction

  task automatic issue(input logic [3:0] m, input logic [31:0] b, input logic [31:0] i,
      input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    mode = m; base_val = b; index_val = i; scale_code = s; disp = d; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // single-step mode: outputs checked the cycle after the accepting edge
  task automatic single(input logic [3:0] m, input logic [31:0] b, input logic [31:0] i,
      input logic [1:0] s, input logic [15:0] d);
    logic [31:0] last_wb;
    last_wb = wb_data;
    issue(m, b, i, s, d);
    if (m > 4'd9) begin
      chk("R11 ea_valid", {31'd0, ea_valid}, 32'd0);
      chk("R11 wb_valid", {31'd0, wb_valid}, 32'd0);
      chk("R11 mem_req", {31'd0, mem_req}, 32'd0);
    end else begin
      chk("R2 ea_valid", {31'd0, ea_valid}, 32'd1);
      chk($sformatf("R3-9 ea mode%0d", m), ea, exp_ea(m, b, i, s, d));
      if (m == 4'd7) begin
        chk("R7 wb_valid", {31'd0, wb_valid}, 32'd1);
        chk("R7 wb_data", wb_data, b + esz(s));
      end else if (m == 4'd8) begin
        chk("R8 wb_valid", {31'd0, wb_valid}, 32'd1);
        chk("R8 wb_data", wb_data, b - esz(s));
      end else begin
        chk("R12 wb_valid", {31'd0, wb_valid}, 32'd0);
        chk("R12 wb_data held", wb_data, last_wb);
      end
    end
  endtask

  task automatic indirect(input logic [31:0] b, input int lat, input bit poke);
    issue(4'd6, b, 32'h0, 2'd0, 16'h0);
    chk("R9 mem_req", {31'd0, mem_req}, 32'd1);
    chk("R9 mem_addr", mem_addr, b);
    chk("R10 busy", {31'd0, busy}, 32'd1);
    chk("R9 no early ea_valid", {31'd0, ea_valid}, 32'd0);
    for (int k = 0; k < lat; k++) begin
      if (poke && k == 0) begin
        issue(4'd7, 32'h100, 32'h0, 2'd2, 16'h0);
        chk("R10 blocked ea_valid", {31'd0, ea_valid}, 32'd0);
        chk("R10 blocked wb_valid", {31'd0, wb_valid}, 32'd0);
        chk("R10 addr kept", mem_addr, b);
      end else begin
        @(negedge clk);
        chk("R9 still waiting", {31'd0, mem_req}, 32'd1);
        chk("R9 no ea_valid", {31'd0, ea_valid}, 32'd0);
      end
    end
    mem_ack = 1'b1;
    mem_rdata = mem_word(mem_addr);
    @(posedge clk);
    @(negedge clk);
    mem_ack = 1'b0;
    mem_rdata = 32'hDEAD_BEEF;
    chk("R9 ea_valid after ack", {31'd0, ea_valid}, 32'd1);
    chk("R9 ea from memory", ea, mem_word(b));
    chk("R9 req dropped", {31'd0, mem_req}, 32'd0);
    chk("R10 busy dropped", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R9 single pulse", {31'd0, ea_valid}, 32'd0);
  endtask

  initial begin
    logic [3:0] m;
    void'($urandom(32'd20240));
    rst = 1'b1; start = 1'b0; mode = 4'd0; base_val = '0; index_val = '0;
    scale_code = '0; disp = '0; mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 ea_valid", {31'd0, ea_valid}, 32'd0);
    chk("R1 wb_valid", {31'd0, wb_valid}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 ea", ea, 32'd0);

    // directed corners
    single(4'd9, 32'h0000_1000, 32'd5, 2'd3, 16'd240);   // R6 offset 280
    chk("R6 example", ea, 32'h0000_1118);
    single(4'd0, 32'hCAFE_0001, 32'h1, 2'd1, 16'h7);      // R3 register
    single(4'd1, 32'h1234_5678, 32'h0, 2'd0, 16'h8001);   // R3 negative imm
    single(4'd2, 32'h8000_0000, 32'h9, 2'd2, 16'h5);      // R4
    single(4'd5, 32'h1111_1111, 32'h0, 2'd0, 16'hFFF0);   // R4 direct negative
    single(4'd3, 32'h0000_0008, 32'h0, 2'd0, 16'hFFF0);   // R5 wrap below zero
    single(4'd4, 32'hFFFF_FFFF, 32'h2, 2'd0, 16'h0);      // R5 wrap
    single(4'd7, 32'hFFFF_FFFC, 32'h0, 2'd2, 16'h0);      // R7 wrap to 0
    single(4'd8, 32'h0000_0000, 32'h0, 2'd2, 16'h0);      // R8 wrap to top
    single(4'd8, 32'h0000_1000, 32'h0, 2'd3, 16'h0);      // R8 step 8
    single(4'd10, 32'h1, 32'h1, 2'd0, 16'h1);             // R11
    single(4'd15, 32'h1, 32'h1, 2'd0, 16'h1);             // R11
    indirect(32'h0000_2000, 0, 1'b0);                      // R9 immediate ack
    indirect(32'h0000_3004, 3, 1'b1);                      // R10 blocked start

    // random traffic
    for (int n = 0; n < 400; n++) begin
      m = 4'($urandom_range(0, 11));
      if (m == 4'd6)
        indirect($urandom, int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
      else
        single(m, $urandom, $urandom, 2'($urandom_range(0, 3)), 16'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule